// File: doc/BRIEF.md
# Mixed-Width Instruction Prefetch Buffer

This block feeds the decode stage of a core whose program holds both 16-bit (compressed) and 32-bit instructions, while its instruction memory only serves aligned 32-bit words. It requests words ahead of use into a four-entry queue. From the queue head it takes out exactly one whole instruction per decode handshake. A 32-bit instruction that begins in the upper half of a word is joined with the lower half of the following word. A compressed instruction is handed over as soon as its own halfword is present.

A redirect from the branch unit empties the queue and marks every memory response still in flight as stale. Fetching then restarts at the word that holds the target. The target may be halfword-aligned; in that case issue begins at the upper half of the first word. The memory side uses request/grant with a separate response-valid strobe, and responses return in order. The decode side uses valid/ready. `dec_valid` never depends on `dec_ready`. While `dec_valid` is high and `dec_ready` is low, the offered instruction and its PC hold still. The only exception is a redirect, which withdraws the offer in the same cycle. Decode may hold `dec_ready` low for any length of time. The buffer then fills and stops requesting, so no word is ever lost.

Top module: `cmix_prefetch`

## Requirements
- R1: After reset `dec_valid` is 0, `dec_pc` equals `BOOT_ADDR`, and `mem_req` is 1 with `mem_addr` equal to `BOOT_ADDR`.
- R2: Every request address is word-aligned (bits 1:0 are 00), and each accepted request (`mem_req` and `mem_gnt` both high) is followed by a request for the next word, address plus 4.
- R3: Queued words plus outstanding requests never exceed four. With decode stalled after a redirect, exactly four requests are accepted and then `mem_req` stays low.
- R4: A halfword whose bits 1:0 are not 11 is a compressed instruction. It is offered with `dec_instr[15:0]` holding it, `dec_instr[31:16]` zero and `dec_is_comp` 1. After it is taken, `dec_pc` advances by 2.
- R5: A halfword whose bits 1:0 are 11 in the lower half of a word starts a 32-bit instruction, offered as the whole word with `dec_is_comp` 0. After it is taken, `dec_pc` advances by 4.
- R6: A 32-bit instruction that starts in the upper half of a word is offered as {lower half of next word, upper half of this word}. `dec_valid` stays 0 until the next word has arrived.
- R7: A compressed instruction in the upper half of a word is offered without waiting for the following word.
- R8: A redirect empties the queue, makes the next request address the word holding the target, and discards responses to requests accepted before it. The first instruction offered afterwards is the one at the target.
- R9: For a halfword-aligned target, `dec_pc` equals the target after the redirect and issue starts at the upper half of the fetched word.
- R10: While `dec_valid` is 1 and `dec_ready` is 0, `dec_instr` and `dec_pc` stay stable and `dec_valid` stays 1. In a redirect cycle `dec_valid` is 0.
- R11: Under any mix of grant delays, response delays and decode stalls, the offered instructions and PCs follow program order exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| redir_valid | input | 1 | Redirect strobe from branch/jump resolution |
| redir_pc | input | AW | Redirect target address (halfword-aligned) |
| mem_req | output | 1 | Word fetch request |
| mem_addr | output | AW | Word-aligned fetch address |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid (in request order) |
| mem_rdata | input | 32 | Read data word |
| dec_valid | output | 1 | Whole instruction offered to decode |
| dec_ready | input | 1 | Decode takes the offered instruction |
| dec_instr | output | 32 | Instruction, compressed ones zero-extended |
| dec_pc | output | AW | Address of the offered instruction |
| dec_is_comp | output | 1 | Offered instruction is 16-bit |

## Verification
A wrong halfword pointer or a lost queue entry shows at the next handshake as an instruction or PC that departs from program order. The stream checks catch it within one issued instruction. A miscounted outstanding or stale-response total shows either as a fifth accepted request while decode is stalled, or as a pre-redirect word appearing first after a redirect. Both are visible within a few cycles of the redirect. A straddle case handled too early shows as `dec_valid` rising while the second word is still held back by the memory model.

// File: rtl/cmix_pkg.sv
package cmix_pkg;

  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  // how the current head position is turned into one instruction
  typedef enum logic [1:0] {
    ISS_NONE  = 2'd0,
    ISS_COMP  = 2'd1,
    ISS_FULL  = 2'd2,
    ISS_SPLIT = 2'd3
  } iss_kind_e;

  // a halfword opens a 32-bit instruction only when its two low bits are set
  function automatic logic half_is_comp(input logic [HALF_W-1:0] h);
    return h[1:0] != 2'b11;
  endfunction

endpackage

// File: rtl/cmix_word_queue.sv
module cmix_word_queue
  import cmix_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop,
  output logic [WORD_W-1:0] head,
  output logic [HALF_W-1:0] next_lo,
  output logic [CNT_W-1:0]  count
);

  logic [WORD_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr, rd_nxt;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign rd_nxt  = bump(rd_ptr);
  assign head    = slot[rd_ptr];
  assign next_lo = slot[rd_nxt][HALF_W-1:0];

  // one register per entry, written only when the write pointer selects it
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot[g] <= '0;
      else if (push && !flush && wr_ptr == PTR_W'(g))
        slot[g] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= rd_nxt;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

endmodule

// File: rtl/cmix_fetch_ctrl.sv
module cmix_fetch_ctrl
  import cmix_pkg::*;
#(
  parameter int              DEPTH     = 4,
  parameter int              AW        = 32,
  parameter logic [AW-1:0]   BOOT_ADDR = '0,
  localparam int             CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             redir_valid,
  input  logic [AW-1:0]    redir_pc,
  input  logic [CNT_W-1:0] q_count,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  output logic             push
);

  localparam logic [CNT_W:0]  LIMIT     = (CNT_W + 1)'(DEPTH);
  localparam logic [AW-1:0]   WORD_MASK = ~AW'(3);

  logic [CNT_W-1:0] out_cnt, out_nxt;   // all accepted, unanswered requests
  logic [CNT_W-1:0] drop_cnt;           // of those, how many are stale
  logic [AW-1:0]    faddr;
  logic             grant;

  // stale requests still hold a queue slot until their answer is gone
  assign mem_req  = ({1'b0, q_count} + {1'b0, out_cnt}) < LIMIT;
  assign mem_addr = faddr;
  assign grant    = mem_req & mem_gnt;
  assign out_nxt  = out_cnt + CNT_W'(grant) - CNT_W'(mem_rvalid);
  assign push     = mem_rvalid & (drop_cnt == '0) & ~redir_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      faddr    <= BOOT_ADDR & WORD_MASK;
      out_cnt  <= '0;
      drop_cnt <= '0;
    end else begin
      out_cnt <= out_nxt;
      if (redir_valid) begin
        faddr    <= redir_pc & WORD_MASK;
        drop_cnt <= out_nxt;
      end else begin
        if (grant) faddr <= faddr + AW'(4);
        if (mem_rvalid && drop_cnt != '0) drop_cnt <= drop_cnt - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/cmix_realign.sv
module cmix_realign
  import cmix_pkg::*;
#(
  parameter int            DEPTH     = 4,
  parameter int            AW        = 32,
  parameter logic [AW-1:0] BOOT_ADDR = '0,
  localparam int           CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_valid,
  input  logic [AW-1:0]     redir_pc,
  input  logic [WORD_W-1:0] head,
  input  logic [HALF_W-1:0] next_lo,
  input  logic [CNT_W-1:0]  q_count,
  output logic              pop,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic [WORD_W-1:0] dec_instr,
  output logic [AW-1:0]     dec_pc,
  output logic              dec_is_comp
);

  localparam logic [AW-1:0] HALF_MASK = ~AW'(1);

  logic [AW-1:0]     pc_q;
  logic              upper;
  logic [HALF_W-1:0] cur_half;
  logic              cur_comp;
  iss_kind_e         kind;
  logic              fire;

  assign upper    = pc_q[1];
  assign cur_half = upper ? head[WORD_W-1:HALF_W] : head[HALF_W-1:0];
  assign cur_comp = half_is_comp(cur_half);

  always_comb begin
    if (q_count == '0)              kind = ISS_NONE;
    else if (cur_comp)              kind = ISS_COMP;
    else if (!upper)                kind = ISS_FULL;
    else if (q_count >= CNT_W'(2))  kind = ISS_SPLIT;
    else                            kind = ISS_NONE;
  end

  always_comb begin
    case (kind)
      ISS_COMP:  dec_instr = {{HALF_W{1'b0}}, cur_half};
      ISS_SPLIT: dec_instr = {next_lo, head[WORD_W-1:HALF_W]};
      default:   dec_instr = head;
    endcase
  end

  assign dec_valid   = (kind != ISS_NONE) & ~redir_valid;
  assign dec_is_comp = cur_comp;
  assign dec_pc      = pc_q;
  assign fire        = dec_valid & dec_ready;
  // the head word is used up once its upper half has been consumed
  assign pop         = fire & ((kind == ISS_FULL) | (kind == ISS_SPLIT) |
                               ((kind == ISS_COMP) & upper));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pc_q <= BOOT_ADDR & HALF_MASK;
    else if (redir_valid)
      pc_q <= redir_pc & HALF_MASK;
    else if (fire)
      pc_q <= pc_q + (cur_comp ? AW'(2) : AW'(4));
  end

endmodule

// File: rtl/cmix_prefetch.sv
module cmix_prefetch
  import cmix_pkg::*;
#(
  parameter int            DEPTH     = 4,
  parameter int            AW        = 32,
  parameter logic [AW-1:0] BOOT_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_valid,
  input  logic [AW-1:0]     redir_pc,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic [WORD_W-1:0] dec_instr,
  output logic [AW-1:0]     dec_pc,
  output logic              dec_is_comp
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]  q_count;
  logic [WORD_W-1:0] q_head;
  logic [HALF_W-1:0] q_next_lo;
  logic              q_push, q_pop;

  cmix_fetch_ctrl #(
    .DEPTH(DEPTH), .AW(AW), .BOOT_ADDR(BOOT_ADDR)
  ) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .redir_valid(redir_valid),
    .redir_pc   (redir_pc),
    .q_count    (q_count),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .push       (q_push)
  );

  cmix_word_queue #(
    .DEPTH(DEPTH)
  ) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (redir_valid),
    .push     (q_push),
    .push_data(mem_rdata),
    .pop      (q_pop),
    .head     (q_head),
    .next_lo  (q_next_lo),
    .count    (q_count)
  );

  cmix_realign #(
    .DEPTH(DEPTH), .AW(AW), .BOOT_ADDR(BOOT_ADDR)
  ) u_align (
    .clk        (clk),
    .rst_n      (rst_n),
    .redir_valid(redir_valid),
    .redir_pc   (redir_pc),
    .head       (q_head),
    .next_lo    (q_next_lo),
    .q_count    (q_count),
    .pop        (q_pop),
    .dec_valid  (dec_valid),
    .dec_ready  (dec_ready),
    .dec_instr  (dec_instr),
    .dec_pc     (dec_pc),
    .dec_is_comp(dec_is_comp)
  );

endmodule

// File: rtl/cmix_prefetch_sva.sv
module cmix_prefetch_sva #(
  parameter int DEPTH = 4,
  parameter int AW    = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          redir_valid,
  input logic [AW-1:0] redir_pc,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_gnt,
  input logic          mem_rvalid,
  input logic          dec_valid,
  input logic          dec_ready,
  input logic [31:0]   dec_instr,
  input logic [AW-1:0] dec_pc,
  input logic          dec_is_comp
);

  localparam logic [AW-1:0] WMASK = ~AW'(3);
  localparam logic [AW-1:0] HMASK = ~AW'(1);

  // outstanding requests as seen purely from the memory port
  logic [7:0] seen_out;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_out <= '0;
    else        seen_out <= seen_out + 8'(mem_req && mem_gnt) - 8'(mem_rvalid);
  end

  p_addr_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt && !redir_valid) |=> mem_addr == $past(mem_addr) + AW'(4));

  p_credit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seen_out <= 8'(DEPTH));

  p_no_req_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_out == 8'(DEPTH)) |-> !mem_req);

  p_comp_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_is_comp == (dec_instr[1:0] != 2'b11)));

  p_comp_zext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_is_comp) |-> dec_instr[31:16] == 16'h0);

  p_comp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_ready && dec_is_comp) |=> dec_pc == $past(dec_pc) + AW'(2));

  p_full_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_ready && !dec_is_comp) |=> dec_pc == $past(dec_pc) + AW'(4));

  p_redir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (!dec_valid && mem_addr == ($past(redir_pc) & WMASK)));

  p_redir_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> dec_pc == ($past(redir_pc) & HMASK));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=>
      (redir_valid || (dec_valid && $stable(dec_instr) && $stable(dec_pc))));

  p_redir_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !dec_valid);

endmodule

bind cmix_prefetch cmix_prefetch_sva #(.DEPTH(DEPTH), .AW(AW)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .redir_valid(redir_valid),
  .redir_pc   (redir_pc),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_gnt    (mem_gnt),
  .mem_rvalid (mem_rvalid),
  .dec_valid  (dec_valid),
  .dec_ready  (dec_ready),
  .dec_instr  (dec_instr),
  .dec_pc     (dec_pc),
  .dec_is_comp(dec_is_comp)
);

// File: tb/cmix_prefetch_tb.sv
module cmix_prefetch_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int NSCEN      = 7;

  // program image as 32 halfwords, wrapping every 64 bytes
  localparam logic [15:0] HW [32] = '{
    16'h0001, 16'h0013, 16'h1234, 16'h4502, 16'h00B3, 16'hABCD, 16'h8082, 16'h0597,
    16'h5555, 16'h1111, 16'h2223, 16'h6789, 16'h0006, 16'h000A, 16'h3333, 16'h7777,
    16'h0F0F, 16'h2468, 16'h4444, 16'hFFFF, 16'h0000, 16'h1357, 16'h9ABC, 16'h8001,
    16'h4003, 16'hC0DE, 16'hBEE3, 16'h0102, 16'h0202, 16'h0303, 16'h0404, 16'h0505
  };

  // {start pc[7:0], ready mode, grant mode, response mode, instructions[7:0]}
  localparam logic [21:0] SCEN [NSCEN] = '{
    {8'd0,  2'd0, 2'd0, 2'd0, 8'd20},
    {8'd2,  2'd1, 2'd1, 2'd1, 8'd20},
    {8'd6,  2'd2, 2'd0, 2'd2, 8'd18},
    {8'd14, 2'd0, 2'd2, 2'd1, 8'd25},
    {8'd26, 2'd1, 2'd0, 2'd0, 8'd20},
    {8'd60, 2'd0, 2'd1, 2'd2, 8'd16},
    {8'd38, 2'd2, 2'd2, 2'd2, 8'd30}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redir_valid = 1'b0;
  logic [31:0] redir_pc = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_gnt;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        dec_valid;
  logic        dec_ready = 1'b0;
  logic [31:0] dec_instr;
  logic [31:0] dec_pc;
  logic        dec_is_comp;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  logic [1:0] gnt_mode = 2'd0;
  logic [1:0] rsp_mode = 2'd0;
  int         rsp_budget = 0;
  int         acc_cnt = 0;
  logic [31:0] acc_log [4];
  logic [31:0] p_addr [8];
  logic [2:0]  p_rd = '0, p_wr = '0;
  int          p_cnt = 0;

  cmix_prefetch u_dut (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .dec_valid(dec_valid),
    .dec_ready(dec_ready), .dec_instr(dec_instr), .dec_pc(dec_pc),
    .dec_is_comp(dec_is_comp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return {HW[5'(a[5:1] + 5'd1)], HW[a[5:1]]};
  endfunction

  function automatic logic [31:0] exp_instr(input logic [31:0] pc);
    logic [15:0] lo, hi;
    lo = HW[pc[5:1]];
    hi = HW[5'(pc[5:1] + 5'd1)];
    return (lo[1:0] != 2'b11) ? {16'h0, lo} : {hi, lo};
  endfunction

  function automatic logic mode_on(input logic [1:0] m);
    case (m)
      2'd0: return 1'b1;
      2'd1: return cyc[0];
      2'd2: return (cyc % 3) != 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: in-order responses, grant and response pacing by mode
  initial begin
    mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (p_cnt > 0 && (rsp_mode == 2'd3 ? rsp_budget > 0 : mode_on(rsp_mode))) begin
        mem_rvalid = 1'b1;
        mem_rdata  = word_at(p_addr[p_rd]);
        p_rd  = p_rd + 3'd1;
        p_cnt = p_cnt - 1;
        if (rsp_mode == 2'd3) rsp_budget = rsp_budget - 1;
      end
      mem_gnt = rst_n && mode_on(gnt_mode);
      if (mem_gnt && mem_req) begin
        p_addr[p_wr] = mem_addr;
        p_wr  = p_wr + 3'd1;
        p_cnt = p_cnt + 1;
        if (acc_cnt < 4) acc_log[acc_cnt] = mem_addr;
        acc_cnt = acc_cnt + 1;
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  task automatic redirect(input logic [31:0] t);
    @(negedge clk);
    redir_valid = 1'b1; redir_pc = t;
    #1;
    chk(!dec_valid, "R10 valid low in redirect cycle", 32'(dec_valid), 0);
    @(negedge clk);
    redir_valid = 1'b0;
  endtask

  initial begin
    logic [31:0] exp_pc, hold_i, hold_p;
    int got, guard;
    bit seen;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!dec_valid, "R1 dec_valid after reset", 32'(dec_valid), 0);
    chk(dec_pc == 32'h0, "R1 dec_pc after reset", dec_pc, 0);
    chk(mem_req && mem_addr == 32'h0, "R1 first request", mem_addr, 0);

    // stream scenarios: program order under varied pacing
    for (int s = 0; s < NSCEN; s++) begin
      @(negedge clk);
      #2;
      gnt_mode = SCEN[s][11:10];
      rsp_mode = SCEN[s][9:8];
      redirect(32'(SCEN[s][21:14]));
      exp_pc = 32'(SCEN[s][21:14]) & ~32'd1;
      got = 0; guard = 0;
      while (got < int'(SCEN[s][7:0]) && guard < 3000) begin
        dec_ready = mode_on(SCEN[s][13:12]);
        #1;
        if (dec_valid && dec_ready) begin
          chk(dec_pc == exp_pc, "R11 pc order", dec_pc, exp_pc);
          chk(dec_instr == exp_instr(exp_pc), "R11 instr (R4/R5/R6 forms)",
              dec_instr, exp_instr(exp_pc));
          chk(dec_is_comp == (exp_instr(exp_pc) >> 16 == 0 &&
                              exp_instr(exp_pc)[1:0] != 2'b11),
              "R4 comp flag", 32'(dec_is_comp), 32'(exp_instr(exp_pc)[1:0] != 2'b11));
          exp_pc = exp_pc + ((exp_instr(exp_pc)[1:0] != 2'b11) ? 32'd2 : 32'd4);
          got++;
        end
        guard++;
        @(negedge clk);
      end
      dec_ready = 1'b0;
      chk(got == int'(SCEN[s][7:0]), "R11 stream completes", 32'(got), 32'(SCEN[s][7:0]));
    end

    // R3 / R2: credit limit with decode stalled
    #2 gnt_mode = 2'd3; rsp_mode = 2'd0;
    repeat (6) @(negedge clk);
    redirect(32'd0);
    #2 acc_cnt = 0; gnt_mode = 2'd0;
    repeat (20) @(negedge clk);
    #1;
    chk(acc_cnt == 4, "R3 accepted requests while stalled", 32'(acc_cnt), 4);
    chk(!mem_req, "R3 request held low when full", 32'(mem_req), 0);
    for (int i = 0; i < 4; i++)
      chk(acc_log[i] == 32'(4 * i), "R2 sequential word addresses", acc_log[i], 32'(4 * i));
    chk(dec_valid && dec_instr == 32'h1 && dec_pc == 0, "R8 first instr at target",
        dec_instr, 32'h1);

    // R10: stall holds the offer
    hold_i = dec_instr; hold_p = dec_pc;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      chk(dec_valid && dec_instr == hold_i && dec_pc == hold_p, "R10 stable under stall",
          dec_instr, hold_i);
    end

    // R6: straddling instruction waits for its second word
    @(negedge clk);
    #2 rsp_mode = 2'd3; rsp_budget = 0;
    redirect(32'd14);
    repeat (6) @(negedge clk);
    #2 rsp_budget = 1;
    repeat (4) @(negedge clk);
    #1;
    chk(!dec_valid, "R6 valid withheld for second half", 32'(dec_valid), 0);
    #1 rsp_budget = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(dec_valid && dec_instr == 32'h55550597 && dec_pc == 32'd14,
        "R6 straddle assembly", dec_instr, 32'h55550597);
    chk(!dec_is_comp, "R6 straddle is 32-bit", 32'(dec_is_comp), 0);

    // R7 / R9: compressed upper half, stale responses dropped first
    redirect(32'd6);
    repeat (4) @(negedge clk);
    #2 rsp_budget = 3;
    repeat (6) @(negedge clk);
    #1;
    chk(dec_valid && dec_instr == 32'h00004502, "R7 upper compressed offered alone",
        dec_instr, 32'h00004502);
    chk(dec_pc == 32'd6 && dec_is_comp, "R9 halfword target pc", dec_pc, 32'd6);
    @(negedge clk);
    dec_ready = 1'b1;
    #1;
    chk(dec_valid, "R7 handshake", 32'(dec_valid), 1);
    @(negedge clk);
    dec_ready = 1'b0;
    #1;
    chk(!dec_valid && dec_pc == 32'd8, "R4 pc plus 2, next word absent", dec_pc, 32'd8);

    // R8: redirect with requests in flight
    redirect(32'd40);
    #1;
    chk(mem_addr == 32'd40, "R8 request restarts at target word", mem_addr, 32'd40);
    #1 rsp_mode = 2'd0;
    seen = 1'b0;
    for (int i = 0; i < 50 && !seen; i++) begin
      @(negedge clk);
      dec_ready = 1'b1;
      #1;
      if (dec_valid) begin
        seen = 1'b1;
        chk(dec_instr == 32'h0 && dec_pc == 32'd40 && dec_is_comp,
            "R8 stale words discarded", dec_instr, 32'h0);
      end
    end
    chk(seen, "R8 target issued", 32'(seen), 1);
    @(negedge clk);
    dec_ready = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule